// File: doc/BRIEF.md
# Single-Lane Execute Stage with Operation Decode

This block is the execute stage for one issue lane of a small pipelined integer core. It receives a 32-bit instruction word together with the two register values already read for it. It works out which arithmetic, logic or compare operation the instruction asks for and forms the second operand. It then computes the result and presents it one clock later with the destination register number and a register-write flag. The lane has no memory access and no branch handling. For loads and stores it produces only the effective address. A core with two lanes places two copies of this block side by side.

The decoder handles two cases differently. When the opcode marks a register-format instruction, the 6-bit function field becomes the ALU operation directly. Any other opcode makes the decoder choose the operation itself. It then uses the zero-extended 16-bit immediate as the second operand. The compare family uses signed arithmetic and always returns exactly 1 or 0. Encodings that the block does not recognise produce a zero result and no register write, so a downstream write-back stage never sees a spurious write.

Top module: `exec_lane`

## Requirements
- R1: While `rst` is high at a rising clock edge, `out_valid`, `reg_we`, `result` and `dest_reg` are all cleared at that edge.
- R2: Each output reflects the instruction presented one rising edge earlier. `out_valid` follows `in_valid` with that delay. `reg_we` is never high while `out_valid` is low.
- R3: The register-format opcode is 000000 (instr[31:26]). With function (instr[5:0]) 100000 the result is rs_val+rt_val, and with 100010 it is rs_val−rt_val, both modulo 2^32. The destination is rd (instr[15:11]) and `reg_we` is 1.
- R4: Register-format functions 100100, 100101 and 100110 give the bitwise AND, OR and XOR of rs_val and rt_val. The destination is rd and the write is enabled.
- R5: Register-format functions 101010 (less), 101011 (greater), 101100 (equal), 101101 (not equal), 101110 (greater-or-equal) and 101111 (less-or-equal) compare rs_val against rt_val as signed 32-bit values. The result is 1 when the relation holds and 0 when it does not, with the destination rd.
- R6: The immediate opcodes are 001000 add, 001010 subtract, 001100 AND, 001101 OR and 001110 XOR. Each applies its operation to rs_val and the zero-extended instr[15:0]. The destination is rt (instr[20:16]) and the write is enabled.
- R7: Opcode 100011 (load) and 101011 (store) both give rs_val plus the zero-extended instr[15:0]. A load enables a write to rt. A store leaves `reg_we` low.
- R8: Opcode 110000 (load-immediate) gives the zero-extended instr[15:0], written to rt.
- R9: Opcode 110011 (move) gives rs_val, written to rd.
- R10: Opcode 111111 (no-operation) and every opcode not listed in R3–R9 give a result of 0 with `reg_we` low and `dest_reg` 0.
- R11: A register-format instruction whose function code is not listed in R3–R5 gives a result of 0 with `reg_we` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word and operands are valid this cycle |
| instr | input | 32 | Instruction word |
| rs_val | input | 32 | Value of the first source register |
| rt_val | input | 32 | Value of the second source register |
| out_valid | output | 1 | Registered result is valid |
| result | output | 32 | Registered ALU result or effective address |
| reg_we | output | 1 | Instruction writes a register |
| dest_reg | output | 5 | Destination register number |

## Verification
Some properties are checked on every clock edge. Unknown opcodes must never raise a write or a nonzero result. The compare functions must never give a value above 1. A write flag must never appear without a valid output. The destination and value for load-immediate and move must track the instruction one cycle later. The directed scenarios are the only place where the arithmetic is shown to be correct. They cover wraparound in add and subtract, the signed-versus-unsigned boundary in each of the six compares, and zero-extension of immediates with the top bit set. They also show that a store keeps the write disabled while still producing its address.

// File: rtl/exec_lane_pkg.sv
package exec_lane_pkg;

  typedef enum logic [5:0] {
    ALU_ZERO  = 6'b000000,
    ALU_PASSA = 6'b000001,
    ALU_PASSB = 6'b000010,
    ALU_ADD   = 6'b100000,
    ALU_SUB   = 6'b100010,
    ALU_AND   = 6'b100100,
    ALU_OR    = 6'b100101,
    ALU_XOR   = 6'b100110,
    ALU_SLT   = 6'b101010,
    ALU_SGT   = 6'b101011,
    ALU_SEQ   = 6'b101100,
    ALU_SNE   = 6'b101101,
    ALU_SGE   = 6'b101110,
    ALU_SLE   = 6'b101111
  } alu_op_e;

  typedef enum logic [1:0] {
    DST_NONE = 2'd0,
    DST_RT   = 2'd1,
    DST_RD   = 2'd2
  } dst_sel_e;

  typedef struct packed {
    alu_op_e  op;
    logic     use_imm;
    logic     wr;
    dst_sel_e dst;
  } lane_ctrl_t;

  localparam logic [5:0] OPC_RFMT = 6'b000000;
  localparam logic [5:0] OPC_ADDI = 6'b001000;
  localparam logic [5:0] OPC_SUBI = 6'b001010;
  localparam logic [5:0] OPC_ANDI = 6'b001100;
  localparam logic [5:0] OPC_ORI  = 6'b001101;
  localparam logic [5:0] OPC_XORI = 6'b001110;
  localparam logic [5:0] OPC_LD   = 6'b100011;
  localparam logic [5:0] OPC_ST   = 6'b101011;
  localparam logic [5:0] OPC_LDI  = 6'b110000;
  localparam logic [5:0] OPC_MOVE = 6'b110011;
  localparam logic [5:0] OPC_IDLE = 6'b111111;

  function automatic logic funct_known(input logic [5:0] f);
    case (f)
      6'b100000, 6'b100010, 6'b100100, 6'b100101, 6'b100110,
      6'b101010, 6'b101011, 6'b101100, 6'b101101, 6'b101110,
      6'b101111: return 1'b1;
      default:   return 1'b0;
    endcase
  endfunction

  function automatic logic opc_writes(input logic [5:0] o);
    case (o)
      OPC_RFMT, OPC_ADDI, OPC_SUBI, OPC_ANDI, OPC_ORI, OPC_XORI,
      OPC_LD, OPC_ST, OPC_LDI, OPC_MOVE: return 1'b1;
      default:                           return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/lane_op_decode.sv
module lane_op_decode
  import exec_lane_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output lane_ctrl_t ctrl
);

  always_comb begin
    ctrl = '{op: ALU_ZERO, use_imm: 1'b0, wr: 1'b0, dst: DST_NONE};
    case (opcode)
      OPC_RFMT: begin
        if (funct_known(funct)) begin
          ctrl.op  = alu_op_e'(funct);
          ctrl.wr  = 1'b1;
          ctrl.dst = DST_RD;
        end
      end
      OPC_ADDI: ctrl = '{op: ALU_ADD,   use_imm: 1'b1, wr: 1'b1, dst: DST_RT};
      OPC_SUBI: ctrl = '{op: ALU_SUB,   use_imm: 1'b1, wr: 1'b1, dst: DST_RT};
      OPC_ANDI: ctrl = '{op: ALU_AND,   use_imm: 1'b1, wr: 1'b1, dst: DST_RT};
      OPC_ORI:  ctrl = '{op: ALU_OR,    use_imm: 1'b1, wr: 1'b1, dst: DST_RT};
      OPC_XORI: ctrl = '{op: ALU_XOR,   use_imm: 1'b1, wr: 1'b1, dst: DST_RT};
      OPC_LD:   ctrl = '{op: ALU_ADD,   use_imm: 1'b1, wr: 1'b1, dst: DST_RT};
      OPC_ST:   ctrl = '{op: ALU_ADD,   use_imm: 1'b1, wr: 1'b0, dst: DST_RT};
      OPC_LDI:  ctrl = '{op: ALU_PASSB, use_imm: 1'b1, wr: 1'b1, dst: DST_RT};
      OPC_MOVE: ctrl = '{op: ALU_PASSA, use_imm: 1'b0, wr: 1'b1, dst: DST_RD};
      default:  ctrl = '{op: ALU_ZERO,  use_imm: 1'b0, wr: 1'b0, dst: DST_NONE};
    endcase
  end

endmodule

// File: rtl/lane_operand_b.sv
module lane_operand_b #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [DATA_W-1:0] rt_val,
  input  logic [IMM_W-1:0]  imm,
  input  logic              use_imm,
  output logic [DATA_W-1:0] opb
);

  logic [DATA_W-1:0] imm_ext;

  generate
    if (DATA_W > IMM_W) begin : g_zext
      assign imm_ext = {{(DATA_W-IMM_W){1'b0}}, imm};
    end else begin : g_trunc
      assign imm_ext = imm[DATA_W-1:0];
    end
  endgenerate

  assign opb = use_imm ? imm_ext : rt_val;

endmodule

// File: rtl/lane_alu.sv
module lane_alu
  import exec_lane_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);

  logic lt, eq;

  assign lt = $signed(a) < $signed(b);
  assign eq = (a == b);

  function automatic logic [DATA_W-1:0] as_bool(input logic f);
    return {{(DATA_W-1){1'b0}}, f};
  endfunction

  always_comb begin
    case (op)
      ALU_ADD:   y = a + b;
      ALU_SUB:   y = a - b;
      ALU_AND:   y = a & b;
      ALU_OR:    y = a | b;
      ALU_XOR:   y = a ^ b;
      ALU_SLT:   y = as_bool(lt);
      ALU_SGT:   y = as_bool(!lt && !eq);
      ALU_SEQ:   y = as_bool(eq);
      ALU_SNE:   y = as_bool(!eq);
      ALU_SGE:   y = as_bool(!lt);
      ALU_SLE:   y = as_bool(lt || eq);
      ALU_PASSA: y = a;
      ALU_PASSB: y = b;
      default:   y = '0;
    endcase
  end

endmodule

// File: rtl/exec_lane.sv
module exec_lane
  import exec_lane_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int RA_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [31:0]       instr,
  input  logic [DATA_W-1:0] rs_val,
  input  logic [DATA_W-1:0] rt_val,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              reg_we,
  output logic [RA_W-1:0]   dest_reg
);

  localparam int RT_LO = 16;
  localparam int RD_LO = 11;

  logic [5:0]        opcode, funct;
  logic [RA_W-1:0]   rt_idx, rd_idx;
  logic [IMM_W-1:0]  imm;
  logic              unused_bits;
  lane_ctrl_t        ctrl;
  logic [DATA_W-1:0] opb, alu_y;
  logic [RA_W-1:0]   dest_nx;

  assign opcode      = instr[31:26];
  assign funct       = instr[5:0];
  assign rt_idx      = instr[RT_LO +: RA_W];
  assign rd_idx      = instr[RD_LO +: RA_W];
  assign imm         = instr[IMM_W-1:0];
  assign unused_bits = ^instr[25:21];

  lane_op_decode u_dec (
    .opcode (opcode),
    .funct  (funct),
    .ctrl   (ctrl)
  );

  lane_operand_b #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opb (
    .rt_val  (rt_val),
    .imm     (imm),
    .use_imm (ctrl.use_imm),
    .opb     (opb)
  );

  lane_alu #(.DATA_W(DATA_W)) u_alu (
    .op (ctrl.op),
    .a  (rs_val),
    .b  (opb),
    .y  (alu_y)
  );

  always_comb begin
    case (ctrl.dst)
      DST_RT:  dest_nx = rt_idx;
      DST_RD:  dest_nx = rd_idx;
      default: dest_nx = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      reg_we    <= 1'b0;
      result    <= '0;
      dest_reg  <= '0;
    end else begin
      out_valid <= in_valid;
      reg_we    <= in_valid && ctrl.wr;
      if (in_valid) begin
        result   <= alu_y;
        dest_reg <= dest_nx;
      end
    end
  end

  // R1: the cycle after a reset edge shows a cleared lane
  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !reg_we && result == '0 && dest_reg == '0));

  // R2: write flag only with a valid result
  p_we_needs_valid_r2: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> out_valid);

  // R2: valid follows the input by one edge
  p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (out_valid == $past(in_valid)));

  // R5: compare functions give 0 or 1 only
  p_cmp_bool_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode == OPC_RFMT && funct[5:3] == 3'b101)
      |=> (result[DATA_W-1:1] == '0));

  // R10: unknown opcodes neither write nor produce a value
  p_unknown_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !opc_writes(opcode)) |=> (!reg_we && result == '0));

  // R8: load-immediate returns the zero-extended field into rt
  p_ldi_value_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode == OPC_LDI)
      |=> (result == DATA_W'($past(imm)) && dest_reg == $past(rt_idx) && reg_we));

  // R9: move writes rd
  p_move_dest_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode == OPC_MOVE)
      |=> (result == $past(rs_val) && dest_reg == $past(rd_idx)));

endmodule

// File: tb/sim_exec_lane.sv
module sim_exec_lane;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] instr, rs_val, rt_val;
  logic        out_valid, reg_we;
  logic [31:0] result;
  logic [4:0]  dest_reg;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  exec_lane u0 (
    .clk (clk), .rst (rst), .in_valid (in_valid), .instr (instr),
    .rs_val (rs_val), .rt_val (rt_val), .out_valid (out_valid),
    .result (result), .reg_we (reg_we), .dest_reg (dest_reg)
  );

  function automatic logic [31:0] rins(input logic [4:0] rd, input logic [5:0] f);
    return {6'b000000, 5'd1, 5'd2, rd, 5'd0, f};
  endfunction

  function automatic logic [31:0] iins(input logic [5:0] op, input logic [4:0] rt,
                                       input logic [15:0] im);
    return {op, 5'd3, rt, im};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive on falling edge, result registered at next rising edge, sample 1 ns later
  task automatic issue(input logic v, input logic [31:0] ins,
                       input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    in_valid = v; instr = ins; rs_val = a; rt_val = b;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic expect_out(input string tag, input logic [31:0] ins,
                            input logic [31:0] a, input logic [31:0] b,
                            input logic [31:0] res, input logic we, input logic [4:0] dst);
    issue(1'b1, ins, a, b);
    check({tag, " valid"}, {31'b0, out_valid}, 32'd1);
    check({tag, " result"}, result, res);
    check({tag, " we"}, {31'b0, reg_we}, {31'b0, we});
    if (we) check({tag, " dest"}, {27'b0, dest_reg}, {27'b0, dst});
  endtask

  task automatic t_reset_r1();
    issue(1'b1, rins(5'd9, 6'b100000), 32'd4, 32'd5);
    @(negedge clk); rst = 1'b1; in_valid = 1'b1;
    @(posedge clk); #1;
    check("R1 valid", {31'b0, out_valid}, 32'd0);
    check("R1 we", {31'b0, reg_we}, 32'd0);
    check("R1 result", result, 32'd0);
    check("R1 dest", {27'b0, dest_reg}, 32'd0);
    @(negedge clk); rst = 1'b0; in_valid = 1'b0;
  endtask

  task automatic t_valid_r2();
    issue(1'b0, rins(5'd7, 6'b100000), 32'd1, 32'd1);
    check("R2 idle valid", {31'b0, out_valid}, 32'd0);
    check("R2 idle we", {31'b0, reg_we}, 32'd0);
  endtask

  task automatic t_addsub_r3();
    expect_out("R3 add", rins(5'd4, 6'b100000), 32'd100, 32'd23, 32'd123, 1'b1, 5'd4);
    expect_out("R3 add wrap", rins(5'd5, 6'b100000), 32'hFFFF_FFFF, 32'd2, 32'd1, 1'b1, 5'd5);
    expect_out("R3 sub", rins(5'd6, 6'b100010), 32'd3, 32'd5, 32'hFFFF_FFFE, 1'b1, 5'd6);
  endtask

  task automatic t_logic_r4();
    expect_out("R4 and", rins(5'd8, 6'b100100), 32'hF0F0_1234, 32'h0FF0_FF00, 32'h00F0_1200, 1'b1, 5'd8);
    expect_out("R4 or",  rins(5'd8, 6'b100101), 32'hF000_0001, 32'h000F_0010, 32'hF00F_0011, 1'b1, 5'd8);
    expect_out("R4 xor", rins(5'd8, 6'b100110), 32'hAAAA_5555, 32'hFFFF_0000, 32'h5555_5555, 1'b1, 5'd8);
  endtask

  task automatic cmp6(input string tag, input logic [31:0] a, input logic [31:0] b,
                      input logic [5:0] exp_bits);
    expect_out({tag, " slt"}, rins(5'd10, 6'b101010), a, b, {31'b0, exp_bits[5]}, 1'b1, 5'd10);
    expect_out({tag, " sgt"}, rins(5'd10, 6'b101011), a, b, {31'b0, exp_bits[4]}, 1'b1, 5'd10);
    expect_out({tag, " seq"}, rins(5'd10, 6'b101100), a, b, {31'b0, exp_bits[3]}, 1'b1, 5'd10);
    expect_out({tag, " sne"}, rins(5'd10, 6'b101101), a, b, {31'b0, exp_bits[2]}, 1'b1, 5'd10);
    expect_out({tag, " sge"}, rins(5'd10, 6'b101110), a, b, {31'b0, exp_bits[1]}, 1'b1, 5'd10);
    expect_out({tag, " sle"}, rins(5'd10, 6'b101111), a, b, {31'b0, exp_bits[0]}, 1'b1, 5'd10);
  endtask

  task automatic t_compare_r5();
    // bits: lt gt eq ne ge le
    cmp6("R5 neg<pos", 32'hFFFF_FFFB, 32'd3, 6'b100101);
    cmp6("R5 equal", 32'd7, 32'd7, 6'b001011);
    cmp6("R5 max>min", 32'h7FFF_FFFF, 32'h8000_0000, 6'b010110);
  endtask

  task automatic t_imm_r6();
    expect_out("R6 addi", iins(6'b001000, 5'd12, 16'h8000), 32'd1, 32'd0, 32'h0000_8001, 1'b1, 5'd12);
    expect_out("R6 subi", iins(6'b001010, 5'd13, 16'd5), 32'd2, 32'd0, 32'hFFFF_FFFD, 1'b1, 5'd13);
    expect_out("R6 andi", iins(6'b001100, 5'd14, 16'hFF0F), 32'hFFFF_FFFF, 32'd0, 32'h0000_FF0F, 1'b1, 5'd14);
    expect_out("R6 ori", iins(6'b001101, 5'd15, 16'h00F0), 32'h1200_0000, 32'd0, 32'h1200_00F0, 1'b1, 5'd15);
    expect_out("R6 xori", iins(6'b001110, 5'd16, 16'hFFFF), 32'h0000_0F0F, 32'hDEAD_BEEF, 32'h0000_F0F0, 1'b1, 5'd16);
  endtask

  task automatic t_mem_r7();
    expect_out("R7 load", iins(6'b100011, 5'd17, 16'hFFFC), 32'h1000_0000, 32'd9, 32'h1000_FFFC, 1'b1, 5'd17);
    expect_out("R7 store", iins(6'b101011, 5'd18, 16'd100), 32'd400, 32'd9, 32'd500, 1'b0, 5'd0);
  endtask

  task automatic t_ldi_r8();
    expect_out("R8 ldi", iins(6'b110000, 5'd19, 16'hBEEF), 32'h1234_5678, 32'd1, 32'h0000_BEEF, 1'b1, 5'd19);
  endtask

  task automatic t_move_r9();
    expect_out("R9 move", {6'b110011, 5'd3, 5'd4, 5'd21, 11'd0}, 32'hCAFE_F00D, 32'd1, 32'hCAFE_F00D, 1'b1, 5'd21);
  endtask

  task automatic t_quiet_r10();
    expect_out("R10 nop", 32'hFFFF_FFFF, 32'd5, 32'd6, 32'd0, 1'b0, 5'd0);
    check("R10 nop dest", {27'b0, dest_reg}, 32'd0);
    expect_out("R10 unknown opc", iins(6'b000100, 5'd22, 16'h1234), 32'd5, 32'd6, 32'd0, 1'b0, 5'd0);
    check("R10 unknown dest", {27'b0, dest_reg}, 32'd0);
  endtask

  task automatic t_badfunct_r11();
    expect_out("R11 funct 000000", rins(5'd23, 6'b000000), 32'd5, 32'd6, 32'd0, 1'b0, 5'd0);
    expect_out("R11 funct 101000", rins(5'd23, 6'b101000), 32'd5, 32'd6, 32'd0, 1'b0, 5'd0);
    expect_out("R11 funct 000010", rins(5'd23, 6'b000010), 32'd5, 32'd6, 32'd0, 1'b0, 5'd0);
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; instr = '0; rs_val = '0; rt_val = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset valid", {31'b0, out_valid}, 32'd0);
    check("R1 reset result", result, 32'd0);
    @(negedge clk); rst = 1'b0;
    t_valid_r2();
    t_addsub_r3();
    t_logic_r4();
    t_compare_r5();
    t_imm_r6();
    t_mem_r7();
    t_ldi_r8();
    t_move_r9();
    t_quiet_r10();
    t_badfunct_r11();
    t_reset_r1();
    repeat (2) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule